// File: doc/BRIEF.md
# Boot-Overlay System Address Decoder

This block sits between a 68010-class CPU bus and the byte-wide storage of a small system. Each access carries a 24-bit address, a transfer size of byte, word or longword, a write strobe and right-justified write data. The block sends the access to one of three regions: boot ROM, main RAM or video RAM. Anything else falls into register space. Multi-byte transfers are big-endian. Each byte lane is indexed on its own, so a transfer that runs off the end of a region's storage wraps back to its start.

After reset a boot overlay is engaged. Address bit 23 of every access is forced high, so the CPU fetches its reset vectors and early code from ROM whatever address it issues. Software releases the overlay by writing a flag in a control register. That register lives at an address that already has bit 23 set, so it stays reachable while the overlay is engaged. The overlay is a two-state machine:
- `MAP_BOOT` is the overlay engaged, and it is the reset state.
- `MAP_NORMAL` is the overlay released.
- The transition `RELEASE` takes `MAP_BOOT` to `MAP_NORMAL` on a control write whose flag bit is 1.
- The transition `ENGAGE` takes `MAP_NORMAL` back to `MAP_BOOT` on a control write whose flag bit is 0.
- A control write that matches the current state keeps it.

A second register drives four active-low status LEDs. Storage sizes are parameters. The default RAM is 1 KiB, down from a production 512 KiB, to keep elaboration small. The video window always decodes its full 32 KiB, but the backing storage defaults to 256 bytes, which alias across the window. ROM contents are computed, not loaded.

Top module: `sysdec_top`

## Requirements
- R1: With the overlay engaged, address bit 23 is forced to 1 before decoding. Any address below 0x400000 then reads ROM byte index (address & (ROM_BYTES-1)), and RAM and video RAM cannot be reached.
- R2: ROM window reads (effective address 0x800000–0xBFFFFF) return the pattern byte for index i = (address+k) & (ROM_BYTES-1). The pattern byte is ((i mod 256)*29 + (i/256 mod 256) + 0x5A) mod 256.
- R3: A write that decodes to the ROM window changes nothing, and later ROM reads return the pattern.
- R4: RAM occupies addresses 0 to RAM_BYTES-1. It is indexed by address & (RAM_BYTES-1), and data written there reads back.
- R5: Video RAM occupies 0x420000–0x427FFF and is indexed by address & (VRAM_BYTES-1). Addresses that differ only above that mask alias to the same storage.
- R6: Regions are checked in this priority order: ROM window, then RAM, then video RAM, then register space.
- R7: Transfer size is encoded 0 = byte, 1 = word, and 2 or 3 = longword. Read data is right-justified and zero-extended. The byte at (address+0) is the most significant, and each byte offset is masked on its own, so a longword at RAM_BYTES-2 uses indices RAM_BYTES-2, RAM_BYTES-1, 0 and 1.
- R8: A read in register space returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R9: A write whose effective address is exactly 0xE43000 loads the overlay flag. The flag comes from data bit 7 for a byte write and from bit 15 for a word or longword write. A flag of 1 releases the overlay and a flag of 0 engages it. Writes to other addresses leave the flag unchanged.
- R10: Only a word write whose effective address is exactly 0x4A0000 loads led_n[3:0] from data bits 11:8. led_n[3] is red, [2] green, [1] yellow, [0] red, and 0 means lit. Byte and longword writes there leave led_n unchanged.
- R11: After reset the overlay is engaged and led_n is 0000, so all LEDs are lit.
- R12: Read data follows the current address within the same cycle. A write takes effect at the rising clock edge where the write strobe is high, so during the write cycle the old data is still read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_size | input | 2 | Transfer size: 0 byte, 1 word, 2/3 longword |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_rdata | output | 32 | Right-justified, zero-extended read data |
| led_n | output | 4 | Active-low status LEDs (red, green, yellow, red) |

## Verification
The assertions check the following on every cycle:
- While the overlay is engaged, no access decodes to RAM or video RAM.
- A control write leaves the overlay state equal to the flag bit that was presented.
- The LED register holds except on a qualifying word write.
- A register-space byte read yields 0xFF, and a byte read never sets upper data bits.

Some behaviour needs the bench's scenarios. These are:
- The big-endian lane order and the wrap of a longword past the end of RAM.
- Aliasing across the video window.
- Whether ROM really stays unchanged after writes.
- The one-cycle delay between a write strobe and the data it changes.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_VRAM = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    localparam logic [1:0]  SZ_BYTE = 2'd0;
    localparam logic [1:0]  SZ_WORD = 2'd1;

    localparam logic [23:0] ROM_LO    = 24'h800000;
    localparam logic [23:0] ROM_HI    = 24'hBFFFFF;
    localparam logic [23:0] VRAM_LO   = 24'h420000;
    localparam logic [23:0] VRAM_HI   = 24'h427FFF;
    localparam logic [23:0] CTRL_ADDR = 24'hE43000;
    localparam logic [23:0] LED_ADDR  = 24'h4A0000;
    localparam logic [23:0] BOOT_BIT  = 24'h800000;

    // number of byte lanes moved by a transfer size code
    function automatic logic [2:0] lane_count(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // computed boot ROM contents
    function automatic logic [7:0] rom_pattern(input logic [23:0] idx);
        logic [7:0] p;
        p = idx[7:0] * 8'd29;
        p = p + idx[15:8] + 8'h5A;
        return p;
    endfunction

endpackage

// File: rtl/sysdec_decode.sv
module sysdec_decode
    import sysdec_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          overlay_on,
    input  logic [23:0]   addr,
    output logic [23:0]   eff_addr,
    output region_e       region
);
    localparam int          RAM_BYTES = 1 << RAM_AW;
    localparam logic [23:0] RAM_LAST  = 24'(RAM_BYTES - 1);

    always_comb begin
        eff_addr = overlay_on ? (addr | BOOT_BIT) : addr;
        if (eff_addr >= ROM_LO && eff_addr <= ROM_HI)
            region = RGN_ROM;
        else if (eff_addr <= RAM_LAST)
            region = RGN_RAM;
        else if (eff_addr >= VRAM_LO && eff_addr <= VRAM_HI)
            region = RGN_VRAM;
        else
            region = RGN_IO;
    end

    AST_OVERLAY_HIDES_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        overlay_on |-> (region != RGN_RAM && region != RGN_VRAM)); // R1

endmodule

// File: rtl/sysdec_bytemem.sv
module sysdec_bytemem #(
    parameter int AW = 10
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [23:0]     base,
    input  logic [2:0]      nbytes,
    input  logic [31:0]     wdata,
    output logic [3:0][7:0] rd_bytes
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]          mem [DEPTH];
    logic [3:0][AW-1:0]  idx;
    logic [3:0][7:0]     lane_data;
    logic [3:0]          lane_en;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            int sh;
            idx[i]     = AW'(base + 24'(i));
            lane_en[i] = wr_en && (i < int'(nbytes));
            sh         = (int'(nbytes) - 1 - i) * 8;
            if (sh < 0)
                sh = 0;
            lane_data[i] = 8'(wdata >> sh);
        end
    end

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_rd
            assign rd_bytes[k] = mem[idx[k]];
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (lane_en[i])
                mem[idx[i]] <= lane_data[i];
    end

endmodule

// File: rtl/sysdec_ctrl.sv
module sysdec_ctrl
    import sysdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [23:0]   eff_addr,
    input  logic [1:0]    size,
    input  logic          flag_byte,
    input  logic          flag_wide,
    input  logic [3:0]    led_bits,
    output logic          overlay_on,
    output logic [3:0]    led_n
);
    typedef enum logic {
        MAP_BOOT   = 1'b0,
        MAP_NORMAL = 1'b1
    } map_e;

    map_e state, state_nx;
    logic ctrl_hit, led_hit, flag_sel;

    assign ctrl_hit = wr_en && (eff_addr == CTRL_ADDR);
    assign led_hit  = wr_en && (eff_addr == LED_ADDR) && (size == SZ_WORD);
    assign flag_sel = (size == SZ_BYTE) ? flag_byte : flag_wide;

    always_comb begin
        state_nx = state;
        unique case (state)
            MAP_BOOT:   if (ctrl_hit && flag_sel)  state_nx = MAP_NORMAL; // RELEASE
            MAP_NORMAL: if (ctrl_hit && !flag_sel) state_nx = MAP_BOOT;   // ENGAGE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= MAP_BOOT;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            led_n <= 4'b0000;
        else if (led_hit)
            led_n <= led_bits;
    end

    assign overlay_on = (state == MAP_BOOT);

    AST_CTRL_LOADS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> ((state == MAP_NORMAL) == $past(flag_sel))); // R9
    AST_LED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !led_hit |=> $stable(led_n)); // R10

endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
    import sysdec_pkg::*;
#(
    parameter int RAM_AW  = 10,
    parameter int VRAM_AW = 8,
    parameter int ROM_AW  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [23:0]   cpu_addr,
    input  logic [1:0]    cpu_size,
    input  logic          cpu_we,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic [3:0]    led_n
);
    logic            overlay_on;
    logic [23:0]     eff_addr;
    region_e         region;
    logic [2:0]      nbytes;
    logic            ram_we, vram_we;
    logic [3:0][7:0] rom_b, ram_b, vram_b, sel_b;

    assign nbytes  = lane_count(cpu_size);
    assign ram_we  = cpu_we && (region == RGN_RAM);
    assign vram_we = cpu_we && (region == RGN_VRAM);

    sysdec_decode #(.RAM_AW(RAM_AW)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .overlay_on (overlay_on),
        .addr       (cpu_addr),
        .eff_addr   (eff_addr),
        .region     (region)
    );

    sysdec_bytemem #(.AW(RAM_AW)) u_ram (
        .clk      (clk),
        .wr_en    (ram_we),
        .base     (eff_addr),
        .nbytes   (nbytes),
        .wdata    (cpu_wdata),
        .rd_bytes (ram_b)
    );

    sysdec_bytemem #(.AW(VRAM_AW)) u_vram (
        .clk      (clk),
        .wr_en    (vram_we),
        .base     (eff_addr),
        .nbytes   (nbytes),
        .wdata    (cpu_wdata),
        .rd_bytes (vram_b)
    );

    sysdec_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_we),
        .eff_addr   (eff_addr),
        .size       (cpu_size),
        .flag_byte  (cpu_wdata[7]),
        .flag_wide  (cpu_wdata[15]),
        .led_bits   (cpu_wdata[11:8]),
        .overlay_on (overlay_on),
        .led_n      (led_n)
    );

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_rom
            logic [ROM_AW-1:0] ridx;
            assign ridx     = ROM_AW'(eff_addr + 24'(k));
            assign rom_b[k] = rom_pattern(24'(ridx));
        end
    endgenerate

    always_comb begin
        unique case (region)
            RGN_ROM:  sel_b = rom_b;
            RGN_RAM:  sel_b = ram_b;
            RGN_VRAM: sel_b = vram_b;
            RGN_IO:   sel_b = {4{8'hFF}};
        endcase
        case (cpu_size)
            SZ_BYTE: cpu_rdata = {24'h0, sel_b[0]};
            SZ_WORD: cpu_rdata = {16'h0, sel_b[0], sel_b[1]};
            default: cpu_rdata = {sel_b[0], sel_b[1], sel_b[2], sel_b[3]};
        endcase
    end

    AST_IO_BYTE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_IO && cpu_size == SZ_BYTE) |-> (cpu_rdata == 32'h0000_00FF)); // R8
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_size == SZ_BYTE) |-> (cpu_rdata[31:8] == 24'h0)); // R7

endmodule

// File: tb/sysdec_top_tb.sv
module sysdec_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAMB  = 1024;
    localparam int VRAMB = 256;
    localparam int ROMB  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  size = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  led_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ram_m  [RAMB];
    logic [7:0] vram_m [VRAMB];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysdec_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_size(size),
        .cpu_we(we), .cpu_wdata(wdata), .cpu_rdata(rdata), .led_n(led_n)
    );

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] rom_exp(input int i);
        int m;
        m = i & (ROMB - 1);
        return 8'(((m & 255) * 29 + ((m >> 8) & 255) + 90) & 255);
    endfunction

    // rgn: 0 rom, 1 ram, 2 vram, 3 miss
    function automatic logic [31:0] exp_rd(input int rgn, input int a, input logic [1:0] sz);
        logic [31:0] v;
        v = 0;
        for (int k = 0; k < nb(sz); k++) begin
            logic [7:0] b;
            case (rgn)
                0: b = rom_exp(a + k);
                1: b = ram_m[(a + k) & (RAMB - 1)];
                2: b = vram_m[(a + k) & (VRAMB - 1)];
                default: b = 8'hFF;
            endcase
            v = {v[23:0], b};
        end
        return v;
    endfunction

    task automatic model_wr(input int rgn, input int a, input logic [1:0] sz, input logic [31:0] d);
        for (int k = 0; k < nb(sz); k++) begin
            logic [7:0] b;
            b = 8'(d >> (8 * (nb(sz) - 1 - k)));
            if (rgn == 1) ram_m[(a + k) & (RAMB - 1)] = b;
            else if (rgn == 2) vram_m[(a + k) & (VRAMB - 1)] = b;
        end
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        addr = a; size = sz; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; size = sz; we = 1'b0;
        #1;
        check(rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({28'h0, led_n}, 32'h0, "R11 led_n after reset");
        // R1/R2: overlay engaged, low addresses read ROM
        rd(24'h000000, 2'd2, exp_rd(0, 0, 2'd2), "R1 R11 reset long read at 0");
        for (int i = 0; i < ROMB; i++)
            rd(24'(i), 2'd0, {24'h0, rom_exp(i)}, "R1 R2 overlay byte sweep");
        for (int i = 0; i < 64; i++)
            rd(24'h3FF000 + 24'(i * 4 + 1), 2'd1, exp_rd(0, 'h3FF000 + i * 4 + 1, 2'd1), "R1 R2 overlay word");
        // R1: write to RAM address during overlay goes to ROM, LED unreachable
        wr(24'h000010, 2'd2, 32'hDEADBEEF);
        wr(24'h4A0000, 2'd1, 32'h0000_0F00);
        #1; check({28'h0, led_n}, 32'h0, "R1 R10 LED hidden by overlay");
        // R9: word with only bit7, wrong address: overlay stays
        wr(24'hE43000, 2'd1, 32'h0000_0080);
        wr(24'hE43001, 2'd0, 32'h0000_0080);
        rd(24'h000004, 2'd2, exp_rd(0, 4, 2'd2), "R9 overlay kept");
        // R9: byte write bit7 releases
        wr(24'hE43000, 2'd0, 32'h0000_0080);
        wr(24'h000000, 2'd0, 32'h0000_0012); model_wr(1, 0, 2'd0, 32'h12);
        rd(24'h000000, 2'd0, 32'h12, "R9 R4 released, RAM byte");
        // R3: ROM untouched by earlier write
        rd(24'h800010, 2'd2, exp_rd(0, 'h10, 2'd2), "R3 R6 ROM after write");
        // R4/R7: RAM sweep
        for (int i = 0; i < RAMB; i += 4) begin
            logic [31:0] d;
            d = 32'(i) * 32'h01030507 ^ 32'hC3A50F1E;
            wr(24'(i), 2'd2, d); model_wr(1, i, 2'd2, d);
        end
        for (int i = 0; i < RAMB; i++)
            rd(24'(i), 2'd0, exp_rd(1, i, 2'd0), "R4 RAM byte");
        for (int i = 1; i < RAMB; i += 6)
            rd(24'(i), 2'd1, exp_rd(1, i, 2'd1), "R7 RAM word");
        for (int i = 2; i < RAMB; i += 10)
            rd(24'(i), 2'd3, exp_rd(1, i, 2'd3), "R7 RAM long size3");
        // R7: wrap at end of RAM
        wr(24'(RAMB - 2), 2'd2, 32'hAABBCCDD); model_wr(1, RAMB - 2, 2'd2, 32'hAABBCCDD);
        rd(24'(RAMB - 2), 2'd2, 32'hAABBCCDD, "R7 long wrap read");
        rd(24'h000000, 2'd1, 32'h0000CCDD, "R7 wrapped lanes at 0");
        // R5: video RAM and aliasing
        for (int i = 0; i < 512; i += 2) begin
            logic [31:0] d;
            d = 32'(i) * 32'h0000_0137 + 32'h0000_2A00;
            wr(24'h420000 + 24'(i), 2'd1, d); model_wr(2, i, 2'd1, d);
        end
        for (int i = 0; i < VRAMB; i++)
            rd(24'h420000 + 24'(i), 2'd0, exp_rd(2, i, 2'd0), "R5 VRAM byte");
        rd(24'h427F00, 2'd2, exp_rd(2, 'h7F00, 2'd2), "R5 VRAM alias top");
        // R8: misses
        rd(24'h500000, 2'd0, 32'h0000_00FF, "R8 miss byte");
        rd(24'h500002, 2'd1, 32'h0000_FFFF, "R8 miss word");
        rd(24'h400000, 2'd2, 32'hFFFF_FFFF, "R8 miss long");
        rd(24'(RAMB), 2'd0, 32'h0000_00FF, "R8 R6 just past RAM");
        rd(24'h428000, 2'd1, 32'h0000_FFFF, "R8 R6 just past VRAM");
        // R10: LEDs
        wr(24'h4A0000, 2'd1, 32'h0000_0A00);
        #1; check({28'h0, led_n}, 32'h0000_000A, "R10 LED word write");
        wr(24'h4A0000, 2'd0, 32'h0000_00FF);
        wr(24'h4A0000, 2'd2, 32'hFFFF_FFFF);
        wr(24'h4A0002, 2'd1, 32'h0000_0F00);
        #1; check({28'h0, led_n}, 32'h0000_000A, "R10 LED ignores byte/long/offset");
        // R3: ROM write in normal mode discarded
        wr(24'h800010, 2'd2, 32'h01234567);
        wr(24'h8003FF, 2'd0, 32'h0000_0000);
        rd(24'h800010, 2'd2, exp_rd(0, 'h10, 2'd2), "R3 ROM long after write");
        rd(24'h8003FF, 2'd0, exp_rd(0, 'h3FF, 2'd0), "R3 ROM byte after write");
        // R12: write timing
        @(negedge clk);
        addr = 24'h000020; size = 2'd2; wdata = 32'h5A5AA5A5; we = 1'b1;
        #1; check(rdata, exp_rd(1, 'h20, 2'd2), "R12 old data during write cycle");
        @(negedge clk);
        we = 1'b0; model_wr(1, 'h20, 2'd2, 32'h5A5AA5A5);
        #1; check(rdata, 32'h5A5AA5A5, "R12 new data after edge");
        // R9: word write flag 0 engages, longword bit15 releases
        wr(24'hE43000, 2'd1, 32'h0000_7FFF);
        rd(24'h000020, 2'd2, exp_rd(0, 'h20, 2'd2), "R9 word clear engages overlay");
        wr(24'h643000, 2'd2, 32'h0000_8000);
        rd(24'h000020, 2'd2, 32'h5A5AA5A5, "R9 long bit15 releases");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule